// File: doc/BRIEF.md
# Tamper Security Supervisor

This block watches ten event lines: eight tamper detectors, a time-counter overflow and a monotonic-counter overflow. From them it keeps the security standing of a battery-backed domain in two flags. The violation flag marks a failure. The non-valid flag marks that the domain lost battery power or still needs recovery. When both flags are clear the domain is valid.

Any event whose enable bit is set latches its own status bit and raises the violation flag. The violation flag drives a freeze line that halts the time counter.

Software sees four registers on a small synchronous bus:
- an event-enable register;
- a lock register, whose lock bits can only be set by writes;
- a status register, cleared by writing ones;
- an interrupt-enable register.

Reset has two domains. The battery power-on reset (`batPorN`, asynchronous, active low) clears everything and leaves the unit non-valid. The system power-on reset (`sysPor`, a one-cycle synchronous pulse) clears only the soft lock and the interrupt enable. When the unit is in failure and the failure hard lock is clear, `sysPor` also moves the unit into the combined non-valid plus failure state. Recovery runs from that combined state in a fixed order:
1. disable the sources;
2. clear the event status bits;
3. clear the violation flag;
4. clear the non-valid flag.

Top module: `tamper_guard`

## Requirements
- R1: After battery reset the status register reads 0x00000002 (non-valid bit 1 set, violation bit 0 clear). The enable, lock and interrupt-enable registers read zero, and `svIrq` and `cntFreeze` are low.
- R2: The register map is: address 0 event enable, 1 locks, 2 status, 3 interrupt enable.
  - Event line i is enabled by enable-register bit i.
  - Enabled event lines 0..7 latch status bits 16..23. Line 8 latches status bit 2 (time overflow) and line 9 latches status bit 3 (monotonic overflow).
  - Every latch also sets the violation flag (status bit 0) at the same clock edge.
  - An event whose enable bit is clear changes nothing.
- R3: While the soft lock (lock bit 29) or the hard lock (lock bit 30) is set, writes to the event-enable register are ignored.
- R4: Lock bits 29, 30 and 16 (failure hard lock) are set by writing 1 and are never cleared by writing 0. `sysPor` clears only bit 29. Bits 30 and 16 are cleared only by battery reset.
- R5: Event status bits are cleared by writing 1 to them at address 2. If the same event is still enabled and active in that cycle, the bit stays set.
- R6: Writing 1 to status bit 0 clears the violation flag only if the non-valid flag is set and every event status bit is zero. Otherwise the write has no effect.
- R7: Writing 1 to status bit 1 clears the non-valid flag only while the violation flag is clear.
- R8: A `sysPor` pulse while the violation flag is set sets the non-valid flag, unless failure hard lock bit 16 is set; in that case the non-valid flag is unchanged. Register writes in a `sysPor` cycle are ignored.
- R9: `cntFreeze` equals the violation flag.
- R10: `svIrq` is high exactly when the violation flag and interrupt-enable bit 0 are both set. `sysPor` clears the interrupt enable.
- R11: `rdData` always returns the register selected by `addr`. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| batPorN | input | 1 | Battery power-on reset, asynchronous, active low |
| sysPor | input | 1 | System power-on reset pulse, synchronous, active high |
| evt | input | 10 | Event lines: 0..7 tamper detectors, 8 time overflow, 9 monotonic overflow |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| svIrq | output | 1 | Security violation interrupt |
| cntFreeze | output | 1 | Halt request for the time counter |

## Verification
The hardest state to reach from the ports is the one where a violation can actually be cleared. The unit must be in failure, then pass through a system reset with the failure hard lock clear to become non-valid again. After that every event source must be disabled and every status bit wiped before the clear write takes effect. A directed sequence walks that exact path. At each step it tries the out-of-order clears and checks that they are refused. Random traffic then mixes sparse events, rare system and battery resets, and lock writes. The hard lock is biased to appear only rarely, so enable writes stay possible for most of the run.

// File: rtl/tamper_guard_pkg.sv
package tamper_guard_pkg;
  localparam int DATA_W = 32;
  localparam int EVT_N = 10;
  localparam int ADDR_W = 2;
  localparam int TAMPER_N = 8;

  localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOCK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_IRQEN = 2'd3;

  localparam int SVF_BIT = 0;
  localparam int NVF_BIT = 1;
  localparam int TOVF_BIT = 2;
  localparam int MOVF_BIT = 3;
  localparam int TAMPER_LO = 16;
  localparam int FAIL_LOCK_BIT = 16;
  localparam int SOFT_LOCK_BIT = 29;
  localparam int HARD_LOCK_BIT = 30;

  typedef struct packed {
    logic wrCfg;
    logic wrLock;
    logic wrIrqEn;
    logic clrEvt;
    logic clrSvf;
    logic clrNvf;
    logic sysRst;
  } strobe_t;

  function automatic logic [DATA_W-1:0] evtToStat(input logic [EVT_N-1:0] e);
    logic [DATA_W-1:0] s;
    s = '0;
    for (int i = 0; i < TAMPER_N; i++) s[TAMPER_LO+i] = e[i];
    s[TOVF_BIT] = e[TAMPER_N];
    s[MOVF_BIT] = e[TAMPER_N+1];
    return s;
  endfunction

  localparam logic [DATA_W-1:0] EVT_MASK = evtToStat('1);
endpackage

// File: rtl/tamper_guard_ctrl.sv
module tamper_guard_ctrl
  import tamper_guard_pkg::*;
(
  input  logic              clk,
  input  logic              batPorN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sysPor,
  input  logic              svf,
  input  logic              nvf,
  input  logic              evtStatZero,
  input  logic              cfgLocked,
  output strobe_t           stb
);
  logic busWr;

  always_comb begin
    busWr       = wrEn && !sysPor;
    stb         = '0;
    stb.sysRst  = sysPor;
    stb.wrCfg   = busWr && (addr == ADDR_CFG) && !cfgLocked;
    stb.wrLock  = busWr && (addr == ADDR_LOCK);
    stb.wrIrqEn = busWr && (addr == ADDR_IRQEN);
    stb.clrEvt  = busWr && (addr == ADDR_STAT);
    stb.clrSvf  = stb.clrEvt && wrData[SVF_BIT] && nvf && evtStatZero;
    stb.clrNvf  = stb.clrEvt && wrData[NVF_BIT] && !svf;
  end

  // R8: writes are dropped in a system reset cycle
  p_sysrst_no_write_r8: assert property (@(posedge clk) disable iff (!batPorN)
    sysPor |-> !(stb.wrCfg || stb.wrLock || stb.clrEvt || stb.wrIrqEn));
endmodule

// File: rtl/tamper_guard_dp.sv
module tamper_guard_dp
  import tamper_guard_pkg::*;
(
  input  logic              clk,
  input  logic              batPorN,
  input  strobe_t           stb,
  input  logic [EVT_N-1:0]  evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              svf,
  output logic              nvf,
  output logic              evtStatZero,
  output logic              cfgLocked,
  output logic              svIrq,
  output logic              cntFreeze
);
  logic [EVT_N-1:0]  cfg;
  logic [DATA_W-1:0] evtStat;
  logic              softLock, hardLock, failLock, irqEn;
  logic [EVT_N-1:0]  hit;
  logic [DATA_W-1:0] clrMask;

  assign hit         = evt & cfg;
  assign clrMask     = stb.clrEvt ? (wrData & EVT_MASK) : '0;
  assign evtStatZero = (evtStat == '0);
  assign cfgLocked   = softLock || hardLock;

  always_ff @(posedge clk or negedge batPorN) begin
    if (!batPorN) begin
      cfg      <= '0;
      evtStat  <= '0;
      softLock <= 1'b0;
      hardLock <= 1'b0;
      failLock <= 1'b0;
      irqEn    <= 1'b0;
      svf      <= 1'b0;
      nvf      <= 1'b1;
    end else begin
      if (stb.wrCfg) cfg <= wrData[EVT_N-1:0];
      if (stb.sysRst) softLock <= 1'b0;
      else if (stb.wrLock && wrData[SOFT_LOCK_BIT]) softLock <= 1'b1;
      if (stb.wrLock && wrData[HARD_LOCK_BIT]) hardLock <= 1'b1;
      if (stb.wrLock && wrData[FAIL_LOCK_BIT]) failLock <= 1'b1;
      if (stb.sysRst) irqEn <= 1'b0;
      else if (stb.wrIrqEn) irqEn <= wrData[0];
      evtStat <= (evtStat & ~clrMask) | evtToStat(hit);
      svf     <= (svf && !stb.clrSvf) || (|hit);
      if (stb.sysRst && svf && !failLock) nvf <= 1'b1;
      else if (stb.clrNvf) nvf <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CFG:  rdData = {{(DATA_W-EVT_N){1'b0}}, cfg};
      ADDR_LOCK: begin
        rdData = '0;
        rdData[SOFT_LOCK_BIT] = softLock;
        rdData[HARD_LOCK_BIT] = hardLock;
        rdData[FAIL_LOCK_BIT] = failLock;
      end
      ADDR_STAT: begin
        rdData = evtStat;
        rdData[SVF_BIT] = svf;
        rdData[NVF_BIT] = nvf;
      end
      default:   rdData = {{(DATA_W-1){1'b0}}, irqEn};
    endcase
  end

  assign svIrq     = svf && irqEn;
  assign cntFreeze = svf;

  // R2: an enabled active event forces the violation flag
  p_hit_sets_svf_r2: assert property (@(posedge clk) disable iff (!batPorN)
    (|(evt & cfg)) |=> svf);
  // R3: a locked enable register holds its value
  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!batPorN)
    (softLock || hardLock) |=> $stable(cfg));
  // R4: hard locks are sticky until battery reset
  p_hard_sticky_r4: assert property (@(posedge clk) disable iff (!batPorN)
    (hardLock && failLock) |=> (hardLock && failLock));
  // R6: violation clears only from non-valid with empty event status
  p_svf_clear_r6: assert property (@(posedge clk) disable iff (!batPorN)
    $fell(svf) |-> ($past(nvf) && ($past(evtStat) == '0)));
  // R7: non-valid clears only after the violation is gone
  p_nvf_clear_r7: assert property (@(posedge clk) disable iff (!batPorN)
    $fell(nvf) |-> !$past(svf));
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamper_guard_pkg::*;
(
  input  logic              clk,
  input  logic              batPorN,
  input  logic              sysPor,
  input  logic [EVT_N-1:0]  evt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              svIrq,
  output logic              cntFreeze
);
  strobe_t stb;
  logic svf, nvf, evtStatZero, cfgLocked;

  tamper_guard_ctrl u_ctrl (
    .clk(clk), .batPorN(batPorN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .sysPor(sysPor), .svf(svf), .nvf(nvf), .evtStatZero(evtStatZero),
    .cfgLocked(cfgLocked), .stb(stb)
  );

  tamper_guard_dp u_dp (
    .clk(clk), .batPorN(batPorN), .stb(stb), .evt(evt), .addr(addr),
    .wrData(wrData), .rdData(rdData), .svf(svf), .nvf(nvf),
    .evtStatZero(evtStatZero), .cfgLocked(cfgLocked), .svIrq(svIrq),
    .cntFreeze(cntFreeze)
  );
endmodule

// File: tb/tamper_guard_tb.sv
`timescale 1ns/1ps
module tamper_guard_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic batPorN = 1'b1, sysPor = 1'b0, wrEn = 1'b0;
  logic [9:0] evt = '0;
  logic [1:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic svIrq, cntFreeze;

  tamper_guard u_dut (.clk(clk), .batPorN(batPorN), .sysPor(sysPor), .evt(evt),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .svIrq(svIrq), .cntFreeze(cntFreeze));

  int nChk = 0, nFail = 0;
  logic [9:0] mCfg;
  logic [31:0] mStat;
  logic mSoft, mHard, mFsh, mSvf, mNvf, mIrqEn;

  function automatic logic [31:0] mapEvt(input logic [9:0] e);
    logic [31:0] s = '0;
    for (int i = 0; i < 8; i++) s[16+i] = e[i];
    s[2] = e[8];
    s[3] = e[9];
    return s;
  endfunction

  function automatic logic [31:0] expWord(input int a);
    case (a)
      0: return {22'b0, mCfg};
      1: return (32'(mHard) << 30) | (32'(mSoft) << 29) | (32'(mFsh) << 16);
      2: return mStat | (32'(mNvf) << 1) | 32'(mSvf);
      default: return {31'b0, mIrqEn};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #0.2;
      check($sformatf("%s R11 addr%0d", req, a), rdData, expWord(a));
    end
    check({req, " R9 freeze"}, 32'(cntFreeze), 32'(mSvf));
    check({req, " R10 irq"}, 32'(svIrq), 32'(mSvf & mIrqEn));
  endtask

  task automatic modelReset();
    mCfg = '0; mStat = '0; mSoft = 0; mHard = 0; mFsh = 0;
    mSvf = 0; mNvf = 1; mIrqEn = 0;
  endtask

  task automatic batReset(input string req);
    @(negedge clk); batPorN = 1'b0;
    @(negedge clk); batPorN = 1'b1;
    modelReset();
    checkAll(req);
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic [9:0] e, input logic sp, input string req);
    logic [9:0] hit, nCfg;
    logic [31:0] nStat;
    logic nSoft, nHard, nFsh, nSvf, nNvf, nIrq, clrSvf;
    @(negedge clk);
    wrEn = we; addr = a; wrData = d; evt = e; sysPor = sp;
    hit = e & mCfg;
    nCfg = mCfg; nStat = mStat; nSoft = mSoft; nHard = mHard; nFsh = mFsh;
    nNvf = mNvf; nIrq = mIrqEn; clrSvf = 0;
    if (sp) begin
      nSoft = 0; nIrq = 0;
      if (mSvf && !mFsh) nNvf = 1;
    end else if (we) begin
      case (a)
        2'd0: if (!(mSoft | mHard)) nCfg = d[9:0];
        2'd1: begin nSoft = mSoft | d[29]; nHard = mHard | d[30]; nFsh = mFsh | d[16]; end
        2'd2: begin
          nStat = mStat & ~(d & mapEvt('1));
          clrSvf = d[0] && mNvf && (mStat == 0);
          if (d[1] && !mSvf) nNvf = 0;
        end
        default: nIrq = d[0];
      endcase
    end
    nStat = nStat | mapEvt(hit);
    nSvf = (mSvf && !clrSvf) || (|hit);
    @(negedge clk);
    wrEn = 0; evt = '0; sysPor = 0;
    mCfg = nCfg; mStat = nStat; mSoft = nSoft; mHard = nHard; mFsh = nFsh;
    mSvf = nSvf; mNvf = nNvf; mIrqEn = nIrq;
    checkAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    batReset("R1 reset state");
    step(1, 2'd2, 32'h2, 0, 0, "R7 clear non-valid while valid");
    step(1, 2'd3, 32'h1, 0, 0, "R10 irq enable");
    step(1, 2'd0, 32'h0DF, 0, 0, "R2 enable most events");
    step(0, 0, 0, 10'h020, 0, "R2 disabled event ignored");
    step(0, 0, 0, 10'h001, 0, "R2 event0 latches bit16");
    step(1, 2'd2, 32'h1, 0, 0, "R6 violation clear refused without non-valid");
    step(1, 2'd2, 32'h2, 0, 0, "R7 non-valid clear refused in failure");
    step(0, 0, 0, 0, 1, "R8 system reset enters non-valid");
    step(1, 2'd2, 32'h1, 0, 0, "R6 violation clear refused with status set");
    step(1, 2'd2, 32'h0001_0000, 10'h001, 0, "R5 active event wins over clear");
    step(1, 2'd0, 32'h300, 0, 0, "R2 enable overflow events");
    step(0, 0, 0, 10'h300, 0, "R2 overflow events latch bits 2 and 3");
    step(1, 2'd0, 32'h0, 0, 0, "R3 disable sources");
    step(1, 2'd2, 32'h00FF_000D, 0, 0, "R5 W1C status, R6 still refused");
    step(1, 2'd2, 32'h3, 0, 0, "R6 violation clears, R7 non-valid kept");
    step(1, 2'd2, 32'h2, 0, 0, "R7 non-valid clears last");
    step(1, 2'd1, 32'h2000_0000, 0, 0, "R4 set soft lock");
    step(1, 2'd0, 32'h3FF, 0, 0, "R3 enable write ignored under soft lock");
    step(1, 2'd1, 32'h0, 0, 0, "R4 zero write keeps soft lock");
    step(1, 2'd0, 32'h3FF, 0, 1, "R4 R8 system reset drops soft lock and write");
    step(1, 2'd0, 32'h004, 0, 0, "R3 enable write after unlock");
    step(1, 2'd1, 32'h4001_0000, 0, 0, "R4 set hard and failure locks");
    step(0, 0, 0, 10'h004, 0, "R2 event2 under hard lock");
    step(0, 0, 0, 0, 1, "R8 failure lock blocks non-valid entry");
    step(1, 2'd0, 32'h0, 0, 0, "R3 hard lock blocks enable write");
    batReset("R1 battery reset clears hard locks");
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] a;
      logic [31:0] d;
      logic [9:0] e;
      if ($urandom % 500 == 0) begin
        batReset("R1 random battery reset");
        continue;
      end
      a = 2'($urandom % 4);
      d = $urandom;
      if (a == 2'd1 && ($urandom % 20 != 0)) d[30] = 1'b0;
      e = ($urandom % 6 == 0) ? 10'(1 << ($urandom % 10)) : 10'h0;
      step(($urandom % 2) == 1, a, d, e, ($urandom % 25) == 0, "R2 R5 random");
    end
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule